// File: doc/BRIEF.md
# SMBus Event Wake/Interrupt Router

This block sits beside an SMBus host/slave controller and decides what each bus event does to the system. It takes single-cycle event pulses from the controller and a level from the alert pin. The pulses cover a slave write of the wake/SMI command, a slave write of the sideband-link SMI command, the host transaction status bits and a received host-notify message. Each event sets a sticky status bit. A small set of software enables, together with the sleeping/awake power state, then decides whether the event leads to a level interrupt, a level SMI request or a one-cycle wake request.

Software reads the status vector and clears bits by writing ones. The interrupt and SMI outputs are derived from the sticky bits and the current enables. They fall only when every contributing bit has been cleared. The wake output is registered and pulses for exactly one cycle per waking event, and only while the system is asleep.

Status vector layout (HOST_W = 4): bits [3:0] latch host status events `ev_host_sts[3:0]`; bit 4 is the slave-SMI flag; bit 5 is the alert flag; bit 6 is the host-notify flag.

Top module: `smb_evt_router`

## Requirements
- R1: While and after reset, until an event arrives, `sts` is all zero and `irq`, `smi` and `wake` are 0.
- R2: `ev_slv_wake` while `asleep`=1 gives `wake`=1 in the following cycle and does not set status bit 4. While `asleep`=0 it sets status bit 4 (raising `smi`) and gives no wake. `en_host_irq` and `en_smi_sel` have no effect on this.
- R3: `ev_link_smi` sets status bit 4 only while `asleep`=0. While asleep it changes nothing, whatever the enables are.
- R4: Each `ev_host_sts[i]` pulse sets status bit i. With `en_host_irq`=0, set host bits cause neither `irq` nor `smi`.
- R5: With `en_host_irq`=1 and any of status bits [3:0] set, `irq`=1 when `en_smi_sel`=0, and `smi`=1 (with no `irq` from them) when `en_smi_sel`=1.
- R6: `ev_notify` sets status bit 6. When `en_notify_wake`=1 and `asleep`=1 it also gives a one-cycle `wake`, whatever the other enables are.
- R7: With `en_notify_irq`=1, status bit 6 drives `irq` when `en_smi_sel`=0. When `en_smi_sel`=1, `ev_notify` instead sets status bit 4. With `en_notify_irq`=0 and `en_notify_wake`=0, a notify raises none of `irq`, `smi` or `wake`.
- R8: A rising edge of `alert_in` sets status bit 5. With `en_alert`=1, bit 5 drives `irq` (`en_smi_sel`=0) or `smi` (`en_smi_sel`=1), and the edge gives a one-cycle `wake` when `asleep`=1. A level held high gives no further wake.
- R9: `irq` and `smi` stay high until every contributing status bit is cleared. A write with `clr_we`=1 clears exactly the bits set in `clr_data`.
- R10: `wake` is high for one cycle per waking event and is never high unless `asleep` was 1 in the event cycle.
- R11: When an event sets a status bit in the same cycle that a write-1-to-clear targets it, the bit ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| asleep | input | 1 | 1 while the system is in a sleep state, 0 when fully on |
| ev_slv_wake | input | 1 | Pulse: slave write of the wake/SMI command |
| ev_link_smi | input | 1 | Pulse: slave write of the sideband-link SMI command |
| ev_host_sts | input | HOST_W | Pulses: host transaction status events |
| ev_notify | input | 1 | Pulse: host-notify message received |
| alert_in | input | 1 | Alert pin level, active high, already synchronized |
| en_host_irq | input | 1 | Host status interrupt enable |
| en_smi_sel | input | 1 | Route enabled events to SMI instead of interrupt |
| en_notify_irq | input | 1 | Host-notify interrupt enable |
| en_notify_wake | input | 1 | Host-notify wake enable |
| en_alert | input | 1 | Alert enable |
| clr_we | input | 1 | Status write strobe |
| clr_data | input | HOST_W+3 | Write-1-to-clear mask for the status vector |
| sts | output | HOST_W+3 | Sticky status vector |
| irq | output | 1 | Level interrupt |
| smi | output | 1 | Level SMI request |
| wake | output | 1 | One-cycle wake request |

## Verification
A status-setting event and a software write-1-to-clear aimed at the same bit can land in the same cycle. This is provoked directly on a host status bit and on the slave-SMI flag, and it recurs often in the random phase, where clears and events are drawn independently each cycle. The outcome is judged by reading the status vector after the edge, which must show the bit still set. The interrupt and SMI levels must also remain asserted as the enables dictate.

// File: rtl/smb_evt_pkg.sv
package smb_evt_pkg;
  localparam int HOST_W_DEF = 4;

  function automatic int idx_slv_smi(input int host_w);
    return host_w;
  endfunction

  function automatic int idx_alert(input int host_w);
    return host_w + 1;
  endfunction

  function automatic int idx_notify(input int host_w);
    return host_w + 2;
  endfunction

  function automatic int sts_width(input int host_w);
    return host_w + 3;
  endfunction
endpackage

// File: rtl/smb_evt_decode.sv
module smb_evt_decode #(
  parameter int HOST_W = smb_evt_pkg::HOST_W_DEF,
  localparam int STS_W = smb_evt_pkg::sts_width(HOST_W),
  localparam int B_SLV = smb_evt_pkg::idx_slv_smi(HOST_W),
  localparam int B_ALR = smb_evt_pkg::idx_alert(HOST_W),
  localparam int B_NTF = smb_evt_pkg::idx_notify(HOST_W)
) (
  input  logic              asleep,
  input  logic              ev_slv_wake,
  input  logic              ev_link_smi,
  input  logic [HOST_W-1:0] ev_host_sts,
  input  logic              ev_notify,
  input  logic              alert_rise,
  input  logic              en_smi_sel,
  input  logic              en_notify_irq,
  input  logic              en_notify_wake,
  input  logic              en_alert,
  output logic [STS_W-1:0]  set_vec,
  output logic              wake_req
);
  logic slv_smi_set;

  always_comb begin
    // Slave SMI flag: awake slave commands, or notify routed to SMI.
    slv_smi_set = (!asleep && (ev_slv_wake || ev_link_smi)) ||
                  (ev_notify && en_notify_irq && en_smi_sel);
    set_vec                = '0;
    set_vec[HOST_W-1:0]    = ev_host_sts;
    set_vec[B_SLV]         = slv_smi_set;
    set_vec[B_ALR]         = alert_rise;
    set_vec[B_NTF]         = ev_notify;
    wake_req = asleep && (ev_slv_wake ||
                          (ev_notify && en_notify_wake) ||
                          (alert_rise && en_alert));
  end
endmodule

// File: rtl/smb_evt_status.sv
module smb_evt_status #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         clr_we,
  input  logic [W-1:0] clr_data,
  output logic [W-1:0] sts
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic bit_q;
    logic bit_d;
    logic bit_en;

    always_comb begin
      bit_en = set_vec[i] || (clr_we && clr_data[i]);
      // A set in the same cycle as a clear wins.
      bit_d  = set_vec[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bit_q <= 1'b0;
      end else if (bit_en) begin
        bit_q <= bit_d;
      end
    end

    assign sts[i] = bit_q;
  end
endmodule

// File: rtl/smb_evt_outputs.sv
module smb_evt_outputs #(
  parameter int HOST_W = smb_evt_pkg::HOST_W_DEF,
  localparam int STS_W = smb_evt_pkg::sts_width(HOST_W),
  localparam int B_SLV = smb_evt_pkg::idx_slv_smi(HOST_W),
  localparam int B_ALR = smb_evt_pkg::idx_alert(HOST_W),
  localparam int B_NTF = smb_evt_pkg::idx_notify(HOST_W)
) (
  input  logic [STS_W-1:0] sts,
  input  logic             en_host_irq,
  input  logic             en_smi_sel,
  input  logic             en_notify_irq,
  input  logic             en_alert,
  output logic             irq,
  output logic             smi
);
  logic host_act;
  logic alert_act;
  logic notify_act;

  always_comb begin
    host_act   = en_host_irq && (|sts[HOST_W-1:0]);
    alert_act  = en_alert && sts[B_ALR];
    notify_act = en_notify_irq && sts[B_NTF];
    irq = !en_smi_sel && (host_act || alert_act || notify_act);
    smi = sts[B_SLV] || (en_smi_sel && (host_act || alert_act));
  end
endmodule

// File: rtl/smb_evt_router.sv
module smb_evt_router #(
  parameter int HOST_W = smb_evt_pkg::HOST_W_DEF,
  localparam int STS_W = smb_evt_pkg::sts_width(HOST_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              asleep,
  input  logic              ev_slv_wake,
  input  logic              ev_link_smi,
  input  logic [HOST_W-1:0] ev_host_sts,
  input  logic              ev_notify,
  input  logic              alert_in,
  input  logic              en_host_irq,
  input  logic              en_smi_sel,
  input  logic              en_notify_irq,
  input  logic              en_notify_wake,
  input  logic              en_alert,
  input  logic              clr_we,
  input  logic [STS_W-1:0]  clr_data,
  output logic [STS_W-1:0]  sts,
  output logic              irq,
  output logic              smi,
  output logic              wake
);
  logic             alert_q;
  logic             alert_d;
  logic             alert_rise;
  logic             wake_q;
  logic             wake_d;
  logic             wake_req;
  logic [STS_W-1:0] set_vec;

  always_comb begin
    alert_rise = alert_in && !alert_q;
    alert_d    = alert_in;
    wake_d     = wake_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alert_q <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      alert_q <= alert_d;
      wake_q  <= wake_d;
    end
  end

  assign wake = wake_q;

  smb_evt_decode #(.HOST_W(HOST_W)) u_decode (
    .asleep         (asleep),
    .ev_slv_wake    (ev_slv_wake),
    .ev_link_smi    (ev_link_smi),
    .ev_host_sts    (ev_host_sts),
    .ev_notify      (ev_notify),
    .alert_rise     (alert_rise),
    .en_smi_sel     (en_smi_sel),
    .en_notify_irq  (en_notify_irq),
    .en_notify_wake (en_notify_wake),
    .en_alert       (en_alert),
    .set_vec        (set_vec),
    .wake_req       (wake_req)
  );

  smb_evt_status #(.W(STS_W)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .clr_we   (clr_we),
    .clr_data (clr_data),
    .sts      (sts)
  );

  smb_evt_outputs #(.HOST_W(HOST_W)) u_outputs (
    .sts           (sts),
    .en_host_irq   (en_host_irq),
    .en_smi_sel    (en_smi_sel),
    .en_notify_irq (en_notify_irq),
    .en_alert      (en_alert),
    .irq           (irq),
    .smi           (smi)
  );
endmodule

// File: rtl/smb_evt_router_chk.sv
module smb_evt_router_chk #(
  parameter int HOST_W = smb_evt_pkg::HOST_W_DEF,
  localparam int STS_W = smb_evt_pkg::sts_width(HOST_W),
  localparam int B_SLV = smb_evt_pkg::idx_slv_smi(HOST_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              asleep,
  input logic              ev_slv_wake,
  input logic              ev_link_smi,
  input logic [HOST_W-1:0] ev_host_sts,
  input logic              clr_we,
  input logic [STS_W-1:0]  clr_data,
  input logic [STS_W-1:0]  sts,
  input logic              irq,
  input logic              smi,
  input logic              wake
);
  logic [STS_W-1:0] host_ext;
  logic [STS_W-1:0] set_and_clr;

  always_comb begin
    host_ext    = STS_W'(ev_host_sts);
    set_and_clr = clr_we ? (host_ext & clr_data) : '0;
  end

  // R2
  slv_cmd_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!asleep && ev_slv_wake) |=> sts[B_SLV]);

  // R3
  link_cmd_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!asleep && ev_link_smi) |=> sts[B_SLV]);

  // R9
  quiet_when_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts == '0) |-> (!irq && !smi));

  // R10
  wake_only_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> $past(asleep));

  // R11
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_and_clr != '0) |=> ((sts & $past(set_and_clr)) == $past(set_and_clr)));
endmodule

bind smb_evt_router smb_evt_router_chk #(.HOST_W(HOST_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .asleep      (asleep),
  .ev_slv_wake (ev_slv_wake),
  .ev_link_smi (ev_link_smi),
  .ev_host_sts (ev_host_sts),
  .clr_we      (clr_we),
  .clr_data    (clr_data),
  .sts         (sts),
  .irq         (irq),
  .smi         (smi),
  .wake        (wake)
);

// File: tb/smb_evt_router_bench.sv
module smb_evt_router_bench;
  localparam int HW = 4;
  localparam int SW = HW + 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          asleep = 1'b0;
  logic          ev_slv_wake = 1'b0;
  logic          ev_link_smi = 1'b0;
  logic [HW-1:0] ev_host_sts = '0;
  logic          ev_notify = 1'b0;
  logic          alert_in = 1'b0;
  logic          en_host_irq = 1'b0;
  logic          en_smi_sel = 1'b0;
  logic          en_notify_irq = 1'b0;
  logic          en_notify_wake = 1'b0;
  logic          en_alert = 1'b0;
  logic          clr_we = 1'b0;
  logic [SW-1:0] clr_data = '0;
  logic [SW-1:0] sts;
  logic          irq;
  logic          smi;
  logic          wake;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [SW-1:0] m_sts = '0;
  logic          m_aq = 1'b0;
  logic          m_wake = 1'b0;

  always #5 clk = ~clk;

  smb_evt_router #(.HOST_W(HW)) u_smb_evt_router (
    .clk(clk), .rst_n(rst_n), .asleep(asleep), .ev_slv_wake(ev_slv_wake),
    .ev_link_smi(ev_link_smi), .ev_host_sts(ev_host_sts), .ev_notify(ev_notify),
    .alert_in(alert_in), .en_host_irq(en_host_irq), .en_smi_sel(en_smi_sel),
    .en_notify_irq(en_notify_irq), .en_notify_wake(en_notify_wake),
    .en_alert(en_alert), .clr_we(clr_we), .clr_data(clr_data),
    .sts(sts), .irq(irq), .smi(smi), .wake(wake)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Expected levels from the requirements: R4, R5, R7, R8, R9.
  function automatic logic exp_irq(input logic [SW-1:0] s);
    logic h = en_host_irq && (s[3:0] != 0);
    logic a = en_alert && s[5];
    logic n = en_notify_irq && s[6];
    return !en_smi_sel && (h || a || n);
  endfunction

  function automatic logic exp_smi(input logic [SW-1:0] s);
    logic h = en_host_irq && (s[3:0] != 0);
    logic a = en_alert && s[5];
    return s[4] || (en_smi_sel && (h || a));
  endfunction

  // Applies the current inputs for one edge, updates the model, compares.
  task automatic step(input string tag);
    logic rise = alert_in && !m_aq;
    logic [SW-1:0] setv;
    setv = {ev_notify, rise,
            (!asleep && (ev_slv_wake || ev_link_smi)) ||
            (ev_notify && en_notify_irq && en_smi_sel),
            ev_host_sts};
    m_wake = asleep && (ev_slv_wake || (ev_notify && en_notify_wake) ||
                        (rise && en_alert));
    m_sts  = (m_sts & ~(clr_we ? clr_data : '0)) | setv;
    m_aq   = alert_in;
    @(posedge clk);
    @(negedge clk);
    chk({tag, " sts"},  32'(sts),  32'(m_sts));
    chk({tag, " irq"},  32'(irq),  32'(exp_irq(m_sts)));
    chk({tag, " smi"},  32'(smi),  32'(exp_smi(m_sts)));
    chk({tag, " wake"}, 32'(wake), 32'(m_wake));
    ev_slv_wake = 1'b0;
    ev_link_smi = 1'b0;
    ev_host_sts = '0;
    ev_notify   = 1'b0;
    clr_we      = 1'b0;
    clr_data    = '0;
  endtask

  task automatic clear_all();
    clr_we = 1'b1;
    clr_data = '1;
    step("clear");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 sts in reset", 32'(sts), 0);
    chk("R1 irq/smi/wake in reset", {29'd0, irq, smi, wake}, 0);
    rst_n = 1'b1;
    step("R1 after reset");
    chk("R1 sts idle", 32'(sts), 0);

    // R2: slave wake command while asleep, enables irrelevant
    asleep = 1'b1; en_host_irq = 1'b1; en_smi_sel = 1'b1;
    ev_slv_wake = 1'b1;
    step("R2 asleep");
    chk("R2 wake asleep", 32'(wake), 1);
    chk("R2 no slave flag asleep", 32'(sts[4]), 0);
    step("R10 pulse end");
    chk("R10 wake one cycle", 32'(wake), 0);
    asleep = 1'b0; en_host_irq = 1'b0; en_smi_sel = 1'b0;
    ev_slv_wake = 1'b1;
    step("R2 awake");
    chk("R2 slave flag awake", 32'(sts[4]), 1);
    chk("R2 smi awake", 32'(smi), 1);
    chk("R2 no wake awake", 32'(wake), 0);
    clr_we = 1'b1; clr_data = 7'h10;
    step("R9 clear slave");
    chk("R9 smi drops", 32'(smi), 0);

    // R3: sideband-link command only when awake
    asleep = 1'b1; en_host_irq = 1'b1; en_smi_sel = 1'b1; en_notify_irq = 1'b1;
    ev_link_smi = 1'b1;
    step("R3 asleep");
    chk("R3 ignored asleep", {25'd0, sts}, 0);
    chk("R3 no outputs asleep", {29'd0, irq, smi, wake}, 0);
    asleep = 1'b0;
    ev_link_smi = 1'b1;
    step("R3 awake");
    chk("R3 flag awake", 32'(sts[4]), 1);
    clear_all();
    en_notify_irq = 1'b0;

    // R4/R5: host status routing
    en_host_irq = 1'b0; en_smi_sel = 1'b0;
    ev_host_sts = 4'b1010;
    step("R4 latch");
    chk("R4 sts bits", 32'(sts), 32'h0a);
    chk("R4 no irq/smi", {30'd0, irq, smi}, 0);
    en_host_irq = 1'b1;
    step("R5 irq");
    chk("R5 irq sel0", {30'd0, irq, smi}, 2);
    en_smi_sel = 1'b1;
    step("R5 smi");
    chk("R5 smi sel1", {30'd0, irq, smi}, 1);
    clr_we = 1'b1; clr_data = 7'h02;
    step("R9 partial");
    chk("R9 smi held", 32'(smi), 1);
    clr_we = 1'b1; clr_data = 7'h08;
    step("R9 full");
    chk("R9 smi off", 32'(smi), 0);

    // R11: set and clear together
    ev_host_sts = 4'b0001;
    step("R11 prep");
    ev_host_sts = 4'b0001; clr_we = 1'b1; clr_data = 7'h01;
    step("R11 collide");
    chk("R11 bit kept", 32'(sts[0]), 1);
    asleep = 1'b0; ev_slv_wake = 1'b1; clr_we = 1'b1; clr_data = 7'h10;
    step("R11 slave collide");
    chk("R11 slave kept", 32'(sts[4]), 1);
    clear_all();

    // R6/R7: host notify
    en_host_irq = 1'b0; en_smi_sel = 1'b0;
    asleep = 1'b1; en_notify_wake = 1'b1; en_notify_irq = 1'b0;
    ev_notify = 1'b1;
    step("R6 wake");
    chk("R6 wake", 32'(wake), 1);
    chk("R6 flag", 32'(sts[6]), 1);
    chk("R6 no irq", 32'(irq), 0);
    en_notify_irq = 1'b1;
    step("R7 irq");
    chk("R7 irq sel0", 32'(irq), 1);
    clear_all();
    en_smi_sel = 1'b1; en_notify_wake = 1'b0;
    ev_notify = 1'b1;
    step("R7 smi");
    chk("R7 slave flag sel1", 32'(sts[4]), 1);
    chk("R7 smi sel1", {30'd0, irq, smi}, 1);
    clear_all();
    en_notify_irq = 1'b0; en_smi_sel = 1'b0;
    ev_notify = 1'b1;
    step("R7 none");
    chk("R7 nothing", {29'd0, irq, smi, wake}, 0);
    clear_all();

    // R8: alert edge
    en_alert = 1'b1; asleep = 1'b1;
    alert_in = 1'b1;
    step("R8 rise");
    chk("R8 flag", 32'(sts[5]), 1);
    chk("R8 irq and wake", {30'd0, irq, wake}, 3);
    step("R8 held");
    chk("R8 no rewake", 32'(wake), 0);
    en_smi_sel = 1'b1;
    step("R8 smi");
    chk("R8 smi sel1", {30'd0, irq, smi}, 1);
    en_alert = 1'b0;
    step("R8 disabled");
    chk("R8 off when disabled", {30'd0, irq, smi}, 0);
    alert_in = 1'b0;
    clear_all();

    // Random phase: all requirements against the model (R9, R10, R11)
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 16 == 0) begin
        {en_host_irq, en_smi_sel, en_notify_irq, en_notify_wake, en_alert} = 5'($urandom);
      end
      if ($urandom % 8 == 0) asleep = ~asleep;
      if ($urandom % 6 == 0) alert_in = ~alert_in;
      ev_slv_wake = ($urandom % 8 == 0);
      ev_link_smi = ($urandom % 8 == 0);
      ev_notify   = ($urandom % 8 == 0);
      for (int b = 0; b < HW; b++) ev_host_sts[b] = ($urandom % 10 == 0);
      clr_we   = ($urandom % 4 == 0);
      clr_data = SW'($urandom);
      step("R9/R11 random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule